// File: doc/BRIEF.md
# Management-Bus Control Register File

This block is the register file of a small board system controller, reached over a two-wire management bus of the MDC/MDIO kind. The management master sends serial frames. Each frame can write a 16-bit control word or read back a control, identifier, status or MAC-address word. The control words leave the block on plain output pins, where routing muxes, reset lines and interrupt gating elsewhere on the board pick them up. The status word is assembled live from input pins when it is read.

MDC and MDIO are sampled in the system clock domain through a synchronizer, and a frame advances one bit on each detected MDC rising edge. The data line is split into an input, an output and an output enable, so the pad and its pull-up stay outside. There is no data stream here: all pins are plain control or status levels, so no valid/ready handshake and no back-pressure apply.

A frame has the following parts, in this order:
- a preamble of at least `PREAMBLE_LEN` ones;
- start bits 0 then 1;
- a 2-bit opcode, sent MSB first (01 = write, 10 = read);
- a 5-bit PHY address, sent MSB first;
- a 5-bit register address, sent MSB first;
- two turnaround bits;
- 16 data bits, sent MSB first.

Top module: `mgmt_regfile`

## Requirements
- R1: After reset, every read/write word is zero, so all control outputs, both key flags and `mdio_oe` are 0. A value of zero in any routing field selects the default route.
- R2: A frame is acted on only if all of the following hold: it follows at least `PREAMBLE_LEN` consecutive ones, its start bits are 0 then 1, its opcode is 01 or 10, and its PHY address equals `PHY_ADDR`. Any other frame changes no word and never drives MDIO.
- R3: The read/write words are at addresses 4, 5, 6, 7, 0xD and 0xE. A write frame to one of them updates it after the last data bit. A later read returns the stored value. Address 4 appears on `adv_o`, 0xD on `mmd_ctrl_o` and 0xE on `mmd_addr_data_o`.
- R4: Reads return fixed or live values at these addresses:
  - 2 returns parameter `ID_HI` and 3 returns `ID_LO`;
  - 9 returns `mac_hi_i`, 0xA returns `mac_mid_i` and 0xB returns `mac_lo_i`.
  
  Writes to these addresses, and to address 8, change nothing.
- R5: All addresses not listed in R3, R4 or R9 (0, 1, 0xC, 0xF and 0x10 to 0x1F) read as zero. Writes to them change nothing.
- R6: On an accepted read, the block leaves MDIO undriven during the first turnaround bit. It drives 0 in the second turnaround bit, then the 16 data bits MSB first. It releases the line after the last data bit. At all other times `mdio_oe` is 0.
- R7: The low byte of the address-7 word drives these outputs:
  - bits 3:0 drive `irq_en_o[3:0]`;
  - bit 4 drives `usb_rst_o`;
  - bit 5 drives `eth_rst_o`;
  - bit 6 drives `mmc_rst_o`;
  - bit 7 drives `eth_clk_en_o`.
- R8: The upper byte of the address-7 word sets the key flags on every write to address 7:
  - 0xE5 sets `wdt_en_o`;
  - 0xA5 sets `extra_en_o`;
  - any other value clears both.
  
  The two flags are never high together.
- R9: Address 8 returns the live status word:
  - bits 3:0 are `irq_src_i`;
  - bits 6:4 are 0;
  - bit 7 is `boot_latched_i`, bit 8 is `boot_in2_i` and bit 9 is `boot_in_i`;
  - bit 10 is `noseq_i` and bit 11 is `noseq_latched_i`;
  - bit 12 is `wd_event_i` and bit 13 is `pwr_good_i`;
  - bit 14 is `wdt_en_o | extra_en_o`;
  - bit 15 is `mac_valid_i`.
- R10: In the address-5 word, bits 11:0 appear on `led_route_o`. Bits 15:12 are not stored and read as 0. The full address-6 word appears on `pin_route_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management bus clock from the master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven on reads |
| mdio_oe | output | 1 | Output enable for the data line |
| irq_src_i | input | 4 | Live interrupt source levels |
| boot_latched_i | input | 1 | Latched boot-mode level |
| boot_in2_i | input | 1 | Second boot-mode input |
| boot_in_i | input | 1 | Live boot-mode input |
| noseq_i | input | 1 | Live no-sequence input |
| noseq_latched_i | input | 1 | Latched no-sequence level |
| wd_event_i | input | 1 | Watchdog event flag |
| pwr_good_i | input | 1 | Power-good level |
| mac_hi_i | input | 16 | MAC address bits 47:32 |
| mac_mid_i | input | 16 | MAC address bits 31:16 |
| mac_lo_i | input | 16 | MAC address bits 15:0 |
| mac_valid_i | input | 1 | MAC address valid |
| adv_o | output | 16 | Advertisement word (address 4) |
| led_route_o | output | 12 | LED routing selects (address 5 bits 11:0) |
| pin_route_o | output | 16 | Pin routing selects (address 6) |
| irq_en_o | output | 4 | Interrupt enables |
| usb_rst_o | output | 1 | USB transceiver reset |
| eth_rst_o | output | 1 | Ethernet transceiver reset |
| mmc_rst_o | output | 1 | MMC reset |
| eth_clk_en_o | output | 1 | Ethernet clock enable |
| wdt_en_o | output | 1 | Watchdog enabled by key |
| extra_en_o | output | 1 | Extra feature enabled by key |
| mmd_ctrl_o | output | 16 | Indirect-access control word (address 0xD) |
| mmd_addr_data_o | output | 16 | Indirect-access address/data word (address 0xE) |

## Verification
The bench builds the block with the following non-default parameters:
- `PHY_ADDR` = 0x13, whose bit pattern mixes ones and zeros;
- `ID_HI` = 0x1A2B and `ID_LO` = 0xC3D4;
- `SYNC_STAGES` = 3.

The non-zero PHY address lets a frame addressed to 0x00, or to any neighbouring address, show that the block rejects it instead of matching by default. The distinct identifier values separate the two identifier words from each other and from zero. The deeper synchronizer stretches the distance from each MDC edge to the block's response. This shows that the bench's bit timing does not rely on a single-stage path. `PREAMBLE_LEN` stays at 32, so a preamble one bit short is within reach of a single test frame.

// File: rtl/mgrf_pkg.sv
package mgrf_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned HDR_W  = 2 + 2 * ADDR_W;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_START,
    FS_HDR,
    FS_TA,
    FS_DATA
  } frame_st_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam logic [ADDR_W-1:0] RA_ID_HI = 5'd2;
  localparam logic [ADDR_W-1:0] RA_ID_LO = 5'd3;
  localparam logic [ADDR_W-1:0] RA_ADV   = 5'd4;
  localparam logic [ADDR_W-1:0] RA_LED   = 5'd5;
  localparam logic [ADDR_W-1:0] RA_PIN   = 5'd6;
  localparam logic [ADDR_W-1:0] RA_CTL   = 5'd7;
  localparam logic [ADDR_W-1:0] RA_STAT  = 5'd8;
  localparam logic [ADDR_W-1:0] RA_MACH  = 5'd9;
  localparam logic [ADDR_W-1:0] RA_MACM  = 5'd10;
  localparam logic [ADDR_W-1:0] RA_MACL  = 5'd11;
  localparam logic [ADDR_W-1:0] RA_MMDC  = 5'd13;
  localparam logic [ADDR_W-1:0] RA_MMDD  = 5'd14;

  localparam logic [7:0] KEY_WDT   = 8'hE5;
  localparam logic [7:0] KEY_EXTRA = 8'hA5;

  localparam int unsigned NUM_RW = 6;

  function automatic logic [ADDR_W-1:0] rw_slot_addr(input int unsigned idx);
    case (idx)
      0:       return RA_ADV;
      1:       return RA_LED;
      2:       return RA_PIN;
      3:       return RA_CTL;
      4:       return RA_MMDC;
      default: return RA_MMDD;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] rw_slot_mask(input int unsigned idx);
    return (idx == 1) ? 16'h0FFF : 16'hFFFF;
  endfunction

  function automatic logic is_rw_addr(input logic [ADDR_W-1:0] a);
    return (a == RA_ADV) || (a == RA_LED) || (a == RA_PIN) ||
           (a == RA_CTL) || (a == RA_MMDC) || (a == RA_MMDD);
  endfunction

endpackage

// File: rtl/mgrf_bit_sampler.sv
module mgrf_bit_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_stb_o,
  output logic bit_val_o
);

  localparam int unsigned STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [STG-1:0] mdc_sync;
  logic [STG-1:0] dat_sync;
  logic           mdc_prev;

  generate
    if (STG == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_sync <= '0;
          dat_sync <= '1;
        end else begin
          mdc_sync <= mdc_i;
          dat_sync <= mdio_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mdc_sync <= '0;
          dat_sync <= '1;
        end else begin
          mdc_sync <= {mdc_sync[STG-2:0], mdc_i};
          dat_sync <= {dat_sync[STG-2:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_prev <= 1'b0;
    else        mdc_prev <= mdc_sync[STG-1];
  end

  assign bit_stb_o = mdc_sync[STG-1] & ~mdc_prev;
  assign bit_val_o = dat_sync[STG-1];

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o) else $error("strobe held"); // R2

endmodule

// File: rtl/mgrf_frame_ctl.sv
module mgrf_frame_ctl
  import mgrf_pkg::*;
#(
  parameter int unsigned       PREAMBLE_LEN = 32,
  parameter logic [ADDR_W-1:0] PHY_ADDR     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int unsigned OCW = $clog2(PREAMBLE_LEN + 1);
  localparam int unsigned BCW = $clog2(WORD_W);
  localparam logic [OCW-1:0] ONES_FULL = OCW'(PREAMBLE_LEN);

  frame_st_e         state_q;
  logic [OCW-1:0]    ones_q;
  logic [BCW-1:0]    cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_nxt;
  logic [WORD_W-1:0] wsr_q;
  logic [WORD_W-1:0] rsr_q;
  logic [ADDR_W-1:0] reg_q;
  logic              act_q;
  logic              rd_q;

  logic [1:0]        hdr_op;
  logic [ADDR_W-1:0] hdr_phy;
  logic              hdr_ok;

  assign hdr_nxt   = {hdr_q[HDR_W-2:0], bit_val_i};
  assign hdr_op    = hdr_nxt[HDR_W-1 -: 2];
  assign hdr_phy   = hdr_nxt[2*ADDR_W-1 -: ADDR_W];
  assign hdr_ok    = (hdr_phy == PHY_ADDR) && ((hdr_op == OP_WR) || (hdr_op == OP_RD));
  assign rd_addr_o = hdr_nxt[ADDR_W-1:0];
  assign wr_addr_o = reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FS_PRE;
      ones_q    <= '0;
      cnt_q     <= '0;
      hdr_q     <= '0;
      wsr_q     <= '0;
      rsr_q     <= '0;
      reg_q     <= '0;
      act_q     <= 1'b0;
      rd_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (bit_stb_i) begin
        unique case (state_q)
          FS_PRE: begin
            if (bit_val_i) begin
              if (ones_q != ONES_FULL) ones_q <= ones_q + 1'b1;
            end else if (ones_q == ONES_FULL) begin
              state_q <= FS_START;
              ones_q  <= '0;
            end else begin
              ones_q <= '0;
            end
          end
          FS_START: begin
            if (bit_val_i) begin
              state_q <= FS_HDR;
              cnt_q   <= '0;
            end else begin
              state_q <= FS_PRE;
            end
          end
          FS_HDR: begin
            hdr_q <= hdr_nxt;
            if (cnt_q == BCW'(HDR_W - 1)) begin
              state_q <= FS_TA;
              cnt_q   <= '0;
              reg_q   <= hdr_nxt[ADDR_W-1:0];
              act_q   <= hdr_ok;
              rd_q    <= (hdr_op == OP_RD);
              rsr_q   <= rd_data_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FS_TA: begin
            if (cnt_q == '0) begin
              cnt_q <= 1'b1;
              if (act_q && rd_q) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              state_q <= FS_DATA;
              cnt_q   <= '0;
              if (act_q && rd_q) begin
                mdio_o <= rsr_q[WORD_W-1];
                rsr_q  <= {rsr_q[WORD_W-2:0], 1'b0};
              end
            end
          end
          FS_DATA: begin
            wsr_q <= {wsr_q[WORD_W-2:0], bit_val_i};
            if (cnt_q == BCW'(WORD_W - 1)) begin
              state_q <= FS_PRE;
              ones_q  <= '0;
              cnt_q   <= '0;
              mdio_oe <= 1'b0;
              if (act_q && !rd_q) begin
                wr_en_o   <= 1'b1;
                wr_data_o <= {wsr_q[WORD_W-2:0], bit_val_i};
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (act_q && rd_q) begin
                mdio_o <= rsr_q[WORD_W-1];
                rsr_q  <= {rsr_q[WORD_W-2:0], 1'b0};
              end
            end
          end
          default: state_q <= FS_PRE;
        endcase
      end
    end
  end

  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (state_q == FS_TA || state_q == FS_DATA)) else $error("oe outside window"); // R6
  AST_TA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o) else $error("turnaround not zero"); // R6
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o) else $error("write pulse held"); // R3
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && state_q == FS_DATA) |-> rd_q) else $error("drive on write"); // R2

endmodule

// File: rtl/mgrf_reg_bank.sv
module mgrf_reg_bank
  import mgrf_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_HI = 16'h0000,
  parameter logic [WORD_W-1:0] ID_LO = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] mac_hi_i,
  input  logic [WORD_W-1:0] mac_mid_i,
  input  logic [WORD_W-1:0] mac_lo_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] adv_w_o,
  output logic [WORD_W-1:0] led_w_o,
  output logic [WORD_W-1:0] pin_w_o,
  output logic [WORD_W-1:0] ctl_w_o,
  output logic [WORD_W-1:0] mmdc_w_o,
  output logic [WORD_W-1:0] mmdd_w_o,
  output logic              wdt_en_o,
  output logic              extra_en_o
);

  logic [NUM_RW-1:0][WORD_W-1:0] slot_vec;
  logic                          ctl_hit;

  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en_i && (wr_addr_i == rw_slot_addr(g)))
          q <= wr_data_i & rw_slot_mask(g);
      end
      assign slot_vec[g] = q;
    end
  endgenerate

  assign adv_w_o  = slot_vec[0];
  assign led_w_o  = slot_vec[1];
  assign pin_w_o  = slot_vec[2];
  assign ctl_w_o  = slot_vec[3];
  assign mmdc_w_o = slot_vec[4];
  assign mmdd_w_o = slot_vec[5];

  assign ctl_hit = wr_en_i && (wr_addr_i == RA_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_en_o   <= 1'b0;
      extra_en_o <= 1'b0;
    end else if (ctl_hit) begin
      wdt_en_o   <= (wr_data_i[WORD_W-1 -: 8] == KEY_WDT);
      extra_en_o <= (wr_data_i[WORD_W-1 -: 8] == KEY_EXTRA);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (is_rw_addr(rd_addr_i)) begin
      for (int i = 0; i < NUM_RW; i++)
        if (rd_addr_i == rw_slot_addr(i)) rd_data_o = slot_vec[i];
    end else begin
      case (rd_addr_i)
        RA_ID_HI: rd_data_o = ID_HI;
        RA_ID_LO: rd_data_o = ID_LO;
        RA_STAT:  rd_data_o = status_i;
        RA_MACH:  rd_data_o = mac_hi_i;
        RA_MACM:  rd_data_o = mac_mid_i;
        RA_MACL:  rd_data_o = mac_lo_i;
        default:  rd_data_o = '0;
      endcase
    end
  end

  AST_KEY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_en_o && extra_en_o)) else $error("both keys set"); // R8
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_hit |=> $stable({wdt_en_o, extra_en_o})) else $error("key flag moved"); // R8
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !is_rw_addr(wr_addr_i)) |=> $stable(slot_vec)) else $error("ro write landed"); // R4
  AST_LED_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    led_w_o[WORD_W-1:12] == 4'h0) else $error("unused led bits"); // R10

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
  import mgrf_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR     = '0,
  parameter logic [WORD_W-1:0] ID_HI        = 16'h0000,
  parameter logic [WORD_W-1:0] ID_LO        = 16'h0000,
  parameter int unsigned       PREAMBLE_LEN = 32,
  parameter int unsigned       SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic [3:0]  irq_src_i,
  input  logic        boot_latched_i,
  input  logic        boot_in2_i,
  input  logic        boot_in_i,
  input  logic        noseq_i,
  input  logic        noseq_latched_i,
  input  logic        wd_event_i,
  input  logic        pwr_good_i,
  input  logic [15:0] mac_hi_i,
  input  logic [15:0] mac_mid_i,
  input  logic [15:0] mac_lo_i,
  input  logic        mac_valid_i,
  output logic [15:0] adv_o,
  output logic [11:0] led_route_o,
  output logic [15:0] pin_route_o,
  output logic [3:0]  irq_en_o,
  output logic        usb_rst_o,
  output logic        eth_rst_o,
  output logic        mmc_rst_o,
  output logic        eth_clk_en_o,
  output logic        wdt_en_o,
  output logic        extra_en_o,
  output logic [15:0] mmd_ctrl_o,
  output logic [15:0] mmd_addr_data_o
);

  logic              bit_stb;
  logic              bit_val;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] led_w;
  logic [WORD_W-1:0] ctl_w;

  mgrf_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_i     (mdc_i),
    .mdio_i    (mdio_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val)
  );

  mgrf_frame_ctl #(.PREAMBLE_LEN(PREAMBLE_LEN), .PHY_ADDR(PHY_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  assign status_w = {mac_valid_i, (wdt_en_o | extra_en_o), pwr_good_i, wd_event_i,
                     noseq_latched_i, noseq_i, boot_in_i, boot_in2_i, boot_latched_i,
                     3'b000, irq_src_i};

  mgrf_reg_bank #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .status_i   (status_w),
    .mac_hi_i   (mac_hi_i),
    .mac_mid_i  (mac_mid_i),
    .mac_lo_i   (mac_lo_i),
    .rd_data_o  (rd_data),
    .adv_w_o    (adv_o),
    .led_w_o    (led_w),
    .pin_w_o    (pin_route_o),
    .ctl_w_o    (ctl_w),
    .mmdc_w_o   (mmd_ctrl_o),
    .mmdd_w_o   (mmd_addr_data_o),
    .wdt_en_o   (wdt_en_o),
    .extra_en_o (extra_en_o)
  );

  assign led_route_o  = led_w[11:0];
  assign irq_en_o     = ctl_w[3:0];
  assign usb_rst_o    = ctl_w[4];
  assign eth_rst_o    = ctl_w[5];
  assign mmc_rst_o    = ctl_w[6];
  assign eth_clk_en_o = ctl_w[7];

  AST_FLAG_FOLLOWS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_en_o || extra_en_o) |-> (ctl_w[15:8] == KEY_WDT || ctl_w[15:8] == KEY_EXTRA))
    else $error("flag without key"); // R8

endmodule

// File: tb/mgmt_regfile_tb_top.sv
module mgmt_regfile_tb_top;

  localparam logic [4:0]  PHY  = 5'h13;
  localparam logic [15:0] IDH  = 16'h1A2B;
  localparam logic [15:0] IDL  = 16'hC3D4;
  localparam int          HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_en = 1'b0, m_drv = 1'b1;
  logic        line;
  logic        d_o, d_oe;
  logic [3:0]  irq_src = '0;
  logic        b_lat = 0, b_in2 = 0, b_in = 0, nsq = 0, nsq_lat = 0, wde = 0, pg = 0, macv = 0;
  logic [15:0] mac_h = 16'h0011, mac_m = 16'h2233, mac_l = 16'h4455;
  logic [15:0] adv, pin, mmdc, mmdd;
  logic [11:0] led;
  logic [3:0]  irq_en;
  logic        usb_rst, eth_rst, mmc_rst, clk_en, wdt, xtra;

  assign line = d_oe ? d_o : (m_en ? m_drv : 1'b1);

  mgmt_regfile #(.PHY_ADDR(PHY), .ID_HI(IDH), .ID_LO(IDL), .PREAMBLE_LEN(32), .SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(line), .mdio_o(d_o), .mdio_oe(d_oe),
    .irq_src_i(irq_src), .boot_latched_i(b_lat), .boot_in2_i(b_in2), .boot_in_i(b_in),
    .noseq_i(nsq), .noseq_latched_i(nsq_lat), .wd_event_i(wde), .pwr_good_i(pg),
    .mac_hi_i(mac_h), .mac_mid_i(mac_m), .mac_lo_i(mac_l), .mac_valid_i(macv),
    .adv_o(adv), .led_route_o(led), .pin_route_o(pin), .irq_en_o(irq_en),
    .usb_rst_o(usb_rst), .eth_rst_o(eth_rst), .mmc_rst_o(mmc_rst), .eth_clk_en_o(clk_en),
    .wdt_en_o(wdt), .extra_en_o(xtra), .mmd_ctrl_o(mmdc), .mmd_addr_data_o(mmdd)
  );

  int checks = 0;
  int errors = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  logic [15:0] mdl [0:31];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rw(input logic [4:0] a);
    return a == 4 || a == 5 || a == 6 || a == 7 || a == 13 || a == 14;
  endfunction

  function automatic logic [15:0] status_exp();
    logic [15:0] s = '0;
    logic [7:0]  key = mdl[7][15:8];
    s[3:0] = irq_src;
    s[7] = b_lat; s[8] = b_in2; s[9] = b_in; s[10] = nsq; s[11] = nsq_lat;
    s[12] = wde; s[13] = pg; s[14] = (key == 8'hE5) || (key == 8'hA5); s[15] = macv;
    return s;
  endfunction

  function automatic logic [15:0] read_exp(input logic [4:0] a);
    if (rw(a)) return mdl[a];
    case (a)
      5'd2:  return IDH;
      5'd3:  return IDL;
      5'd8:  return status_exp();
      5'd9:  return mac_h;
      5'd10: return mac_m;
      5'd11: return mac_l;
      default: return 16'h0000;
    endcase
  endfunction

  // per-clock comparison against the behavioural model
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !busy && !done) begin
        chk("R3 adv", adv, mdl[4]);
        chk("R10 led", led, mdl[5][11:0]);
        chk("R10 pin", pin, mdl[6]);
        chk("R7 irq_en", irq_en, mdl[7][3:0]);
        chk("R7 resets/clk", {clk_en, mmc_rst, eth_rst, usb_rst}, mdl[7][7:4]);
        chk("R8 wdt", wdt, mdl[7][15:8] == 8'hE5);
        chk("R8 extra", xtra, mdl[7][15:8] == 8'hA5);
        chk("R3 mmd", {mmdc, mmdd}, {mdl[13], mdl[14]});
        chk("R6 idle release", d_oe, 1'b0);
      end
    end
  end

  task automatic send_bit(input logic v, input logic en, output logic ln, output logic oe);
    @(negedge clk);
    m_en = en; m_drv = v;
    repeat (HALF) @(negedge clk);
    ln = line; oe = d_oe;
    if (en && d_oe) chk("R6 contention", 1, 0);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic run_frame(input int pre, input bit lead0, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                           output logic [15:0] rd, output int drv, output logic ta1_oe,
                           output logic ta2_ln);
    logic ln, oe;
    logic [11:0] hdr = {op, phy, ra};
    bit is_rd = (op == 2'b10);
    drv = 0; rd = '0;
    if (lead0) send_bit(1'b0, 1'b1, ln, oe);
    for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b1, ln, oe);
    send_bit(1'b0, 1'b1, ln, oe);
    send_bit(1'b1, 1'b1, ln, oe);
    for (int i = 11; i >= 0; i--) send_bit(hdr[i], 1'b1, ln, oe);
    send_bit(1'b1, !is_rd, ln, oe); ta1_oe = oe; if (oe) drv++;
    send_bit(1'b0, !is_rd, ln, oe); ta2_ln = ln; if (oe) drv++;
    for (int i = 15; i >= 0; i--) begin
      send_bit(wd[i], !is_rd, ln, oe);
      rd[i] = ln;
      if (oe) drv++;
    end
    send_bit(1'b1, 1'b0, ln, oe);
    chk("R6 released after frame", oe, 1'b0);
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd; int drv; logic t1, t2;
    busy = 1;
    run_frame(32, 0, 2'b01, PHY, ra, wd, rd, drv, t1, t2);
    chk("R2 no drive on write", drv, 0);
    if (rw(ra)) mdl[ra] = (ra == 5) ? (wd & 16'h0FFF) : wd;
    busy = 0;
  endtask

  task automatic do_read(input logic [4:0] ra, input string req);
    logic [15:0] rd, exp; int drv; logic t1, t2;
    busy = 1;
    exp = read_exp(ra);
    run_frame(32, 0, 2'b10, PHY, ra, 16'h0, rd, drv, t1, t2);
    chk(req, rd, exp);
    chk("R6 ta1 undriven", t1, 1'b0);
    chk("R6 ta2 zero", t2, 1'b0);
    chk("R6 driven bits", drv, 17);
    busy = 0;
  endtask

  task automatic bad_frame(input int pre, input bit lead0, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                           input string req);
    logic [15:0] rd; int drv; logic t1, t2;
    busy = 1;
    run_frame(pre, lead0, op, phy, ra, wd, rd, drv, t1, t2);
    chk(req, drv, 0);
    busy = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 adv", adv, 0); chk("R1 led", led, 0); chk("R1 pin", pin, 0);
    chk("R1 ctl", {irq_en, usb_rst, eth_rst, mmc_rst, clk_en}, 0);
    chk("R1 keys", {wdt, xtra}, 0); chk("R1 mmd", {mmdc, mmdd}, 0); chk("R1 oe", d_oe, 0);
    busy = 0;

    do_read(5'd2, "R4 id hi");
    do_read(5'd3, "R4 id lo");
    do_read(5'd4, "R1 adv reads zero");

    do_write(5'd4, 16'hA55A);  do_read(5'd4, "R3 adv");
    do_write(5'd5, 16'hF123);  do_read(5'd5, "R10 led top bits zero");
    do_write(5'd6, 16'hBEEF);  do_read(5'd6, "R10 pin");
    do_write(5'd13, 16'h1234); do_read(5'd13, "R3 mmd ctrl");
    do_write(5'd14, 16'h5678); do_read(5'd14, "R3 mmd addr/data");

    do_write(5'd7, 16'hE5AB); do_read(5'd7, "R7 ctl word");
    chk("R8 wdt key", wdt, 1'b1);
    do_read(5'd8, "R9 status with wdt");
    do_write(5'd7, 16'hA554);
    chk("R8 extra key", xtra, 1'b1); chk("R8 wdt cleared", wdt, 1'b0);
    chk("R7 usb/mmc set", {mmc_rst, usb_rst}, 2'b11);
    do_write(5'd7, 16'h5AFF);
    chk("R8 other key", {wdt, xtra}, 2'b00);
    do_write(5'd7, 16'hE400);
    chk("R8 near key", {wdt, xtra}, 2'b00);

    irq_src = 4'b1010; b_lat = 1; b_in2 = 0; b_in = 1; nsq = 0; nsq_lat = 1;
    wde = 1; pg = 0; macv = 1;
    do_read(5'd8, "R9 status pattern A");
    irq_src = 4'b0101; b_lat = 0; b_in2 = 1; b_in = 0; nsq = 1; nsq_lat = 0;
    wde = 0; pg = 1; macv = 0;
    do_read(5'd8, "R9 status pattern B");

    mac_h = 16'hDEAD; mac_m = 16'hBEEF; mac_l = 16'hC0DE;
    do_read(5'd9, "R4 mac hi"); do_read(5'd10, "R4 mac mid"); do_read(5'd11, "R4 mac lo");

    do_write(5'd2, 16'hFFFF); do_read(5'd2, "R4 id write ignored");
    do_write(5'd8, 16'hFFFF); do_read(5'd8, "R4 status write ignored");
    do_write(5'd9, 16'h0000); do_read(5'd9, "R4 mac write ignored");
    do_write(5'd12, 16'h7777); do_read(5'd12, "R5 reserved 0xC");
    do_write(5'd31, 16'h7777); do_read(5'd31, "R5 reserved 0x1F");
    do_read(5'd0, "R5 reserved 0"); do_read(5'd15, "R5 reserved 0xF");

    bad_frame(32, 0, 2'b01, 5'h00, 5'd4, 16'h0F0F, "R2 wrong phy write");
    bad_frame(32, 0, 2'b01, 5'h12, 5'd6, 16'h0F0F, "R2 near phy write");
    bad_frame(32, 0, 2'b10, 5'h00, 5'd4, 16'h0000, "R2 wrong phy read");
    bad_frame(31, 1, 2'b01, PHY, 5'd4, 16'h0F0F, "R2 short preamble");
    bad_frame(32, 0, 2'b11, PHY, 5'd4, 16'h0F0F, "R2 bad opcode 11");
    bad_frame(32, 0, 2'b00, PHY, 5'd6, 16'h0F0F, "R2 bad opcode 00");
    do_read(5'd4, "R2 adv unchanged");
    do_read(5'd6, "R2 pin unchanged");

    do_write(5'd7, 16'h0000);
    do_read(5'd8, "R9 status flag clear");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule